// File: doc/BRIEF.md
# Doorbell-Gated Command Sequencer

This block reads command bytes from a small internal byte queue and runs them one at a time. A signed 8-bit permit counter (the doorbell) controls the work. Software loads one or more complete sequences into the queue, with each sequence opened by a bus-acquire byte and closed by a bus-release byte. Software then adds the number of sequences to the counter in a single write. Each bus-acquire that runs takes one permit. A bus-acquire that reaches the head of the queue while the counter is zero or negative holds there, and nothing behind it runs.

The rest of the command set is small. A wait opcode is followed by a 16-bit cycle count, low byte first, and the sequencer counts that many cycles before it fetches the next byte. Every other byte value is passed to the byte output as a payload strobe. A hold input freezes the set of bytes that may still execute: bytes already queued when hold rises still run, and bytes pushed after that wait until hold drops. The block also reports an idle flag and a sticky flag that marks an illegal executor state.

Top module: `dbell_seq`

## Requirements
- R1: After reset the permit count is 0, `idle` is 1, and `bus_owned`, `out_valid`, `cmd_full` and `sm_bad` are all 0.
- R2: A pulse on `db_wr` adds `db_val`, read as two's complement, to the count modulo 256. The new count is visible on `db_count` after the same clock edge. For example, 0x7F added twice gives 0xFE.
- R3: The acquire opcode is 0x01. It is consumed only when the signed count is positive. Consuming it lowers the count by 1 and sets `bus_owned`. The release opcode 0x02 clears `bus_owned`.
- R4: An acquire at the head of the queue with a signed count of zero or less is not consumed. No byte behind it executes until writes make the count positive.
- R5: A doorbell write on the same edge that an acquire is consumed leaves the count at count + value − 1.
- R6: One doorbell write of N releases exactly N queued sequences. The next acquire then holds.
- R7: Every byte other than 0x01, 0x02 and 0x03, when executed, shows on `out_byte` with `out_valid` high for exactly one cycle, in queue order.
- R8: The wait opcode 0x03 takes the next two bytes as a count N, low byte first. The byte that follows is emitted on the edge N+3 edges after the edge that took the opcode, provided the queue holds it.
- R9: While `exec_hold` is 1, only the bytes that were queued when it rose may execute. Bytes pushed later wait until `exec_hold` returns to 0.
- R10: `idle` is 1 exactly when the queue is empty, the executor is in its fetch state, and the bus is not owned.
- R11: A push into a full queue is dropped, and `cmd_full` is 1 whenever DEPTH bytes are queued.
- R12: `sm_bad` stays 0 while the executor passes only through legal states. It becomes sticky 1 if the state register ever holds an illegal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push `cmd_byte` into the command queue |
| cmd_byte | input | 8 | Command byte to push |
| cmd_full | output | 1 | Queue holds DEPTH bytes |
| db_wr | input | 1 | Add `db_val` to the permit count |
| db_val | input | CNT_W | Signed amount to add |
| db_count | output | CNT_W | Current permit count, two's complement |
| exec_hold | input | 1 | Restrict execution to bytes queued before it rose |
| bus_owned | output | 1 | Set by acquire, cleared by release |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| idle | output | 1 | Queue empty and no sequence open |
| sm_bad | output | 1 | Sticky illegal-state flag |

## Verification
A byte pushed on one edge is fetched no earlier than the next edge, and its payload strobe is registered on that fetch edge. The bench therefore drives inputs at falling edges and compares the payload only when it samples `out_valid` at a falling edge. It uses a queue of expected bytes, so a byte that comes out early or late still has to match in order, and any strobe with nothing expected is a failure. The doorbell count changes on the edge where the write is seen, so it is checked at the very next falling edge. The wait latency is measured by counting falling edges from the release of `exec_hold` to the strobe: 4 for N=0 and 9 for N=5.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WAIT_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_ACQ  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_REL  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_WAIT = 8'h03;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_WLO   = 3'd1,
        ST_WHI   = 3'd2,
        ST_COUNT = 3'd3,
        ST_HOLD  = 3'd4
    } exec_state_e;

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    occ
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign occ   = q.cnt;
    assign head  = mem[q.rp];
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;

    always_comb begin
        d = q;
        if (wr_ok) d.wp = step(q.wp);
        if (rd_ok) d.rp = step(q.rp);
        case ({wr_ok, rd_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[q.wp] <= din;
    end

endmodule

// File: rtl/db_counter.sv
module db_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take,
    output logic [CNT_W-1:0] count,
    output logic             positive
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dbc_t;

    dbc_t q, d;

    always_comb begin
        d = q;
        // modular sum: signed add and unit decrement share one adder chain
        d.cnt = q.cnt + (add_en ? add_val : '0) - {{(CNT_W-1){1'b0}}, take};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.cnt;
    assign positive = !q.cnt[CNT_W-1] && (q.cnt != '0);

endmodule

// File: rtl/seq_exec.sv
module seq_exec
    import dbseq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] head,
    input  logic              empty,
    input  logic [CW-1:0]     occ,
    input  logic              push_ok,
    input  logic              hold,
    input  logic              permit,
    output logic              pop,
    output logic              take,
    output logic              bus_own,
    output logic              ovalid,
    output logic [BYTE_W-1:0] obyte,
    output logic              core_idle,
    output logic              bad
);

    typedef struct packed {
        exec_state_e       state;
        logic [WAIT_W-1:0] wcnt;
        logic [BYTE_W-1:0] wlo;
        logic [CW-1:0]     allow;
        logic              bus_own;
        logic              ovalid;
        logic [BYTE_W-1:0] obyte;
        logic              bad;
    } exec_t;

    exec_t q, d;
    logic allowed, can_pop, illegal;

    always_comb begin
        d       = q;
        d.ovalid = 1'b0;
        pop     = 1'b0;
        take    = 1'b0;
        illegal = 1'b0;
        allowed = hold ? (q.allow != '0) : 1'b1;
        can_pop = !empty && allowed;

        case (q.state)
            ST_FETCH, ST_HOLD: begin
                d.state = ST_FETCH;
                if (can_pop) begin
                    if (head == OP_ACQ) begin
                        if (permit) begin
                            pop       = 1'b1;
                            take      = 1'b1;
                            d.bus_own = 1'b1;
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end else if (head == OP_REL) begin
                        pop       = 1'b1;
                        d.bus_own = 1'b0;
                    end else if (head == OP_WAIT) begin
                        pop     = 1'b1;
                        d.state = ST_WLO;
                    end else begin
                        pop      = 1'b1;
                        d.ovalid = 1'b1;
                        d.obyte  = head;
                    end
                end
            end
            ST_WLO: begin
                if (can_pop) begin
                    pop     = 1'b1;
                    d.wlo   = head;
                    d.state = ST_WHI;
                end
            end
            ST_WHI: begin
                if (can_pop) begin
                    pop     = 1'b1;
                    d.wcnt  = {head, q.wlo};
                    d.state = ({head, q.wlo} == '0) ? ST_FETCH : ST_COUNT;
                end
            end
            ST_COUNT: begin
                d.wcnt = q.wcnt - 1'b1;
                if (q.wcnt == WAIT_W'(1)) d.state = ST_FETCH;
            end
            default: begin
                illegal = 1'b1;
                d.state = ST_FETCH;
            end
        endcase

        d.bad = q.bad | illegal;

        // bytes eligible under hold: snapshot of occupancy, drained by pops only
        if (hold) d.allow = q.allow - CW'(pop);
        else      d.allow = occ + CW'(push_ok) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_FETCH;
        end else begin
            q <= d;
        end
    end

    assign bus_own   = q.bus_own;
    assign ovalid    = q.ovalid;
    assign obyte     = q.obyte;
    assign core_idle = (q.state == ST_FETCH) && !q.bus_own;
    assign bad       = q.bad;

endmodule

// File: rtl/dbell_seq.sv
module dbell_seq
    import dbseq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_push,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_full,
    input  logic              db_wr,
    input  logic [CNT_W-1:0]  db_val,
    output logic [CNT_W-1:0]  db_count,
    input  logic              exec_hold,
    output logic              bus_owned,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              idle,
    output logic              sm_bad
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] q_head;
    logic              q_empty;
    logic [CW-1:0]     q_occ;
    logic              q_pop;
    logic              acq_take;
    logic              permit;
    logic              core_idle;

    seq_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .din   (cmd_byte),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (cmd_full),
        .occ   (q_occ)
    );

    db_counter #(.CNT_W(CNT_W)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (db_wr),
        .add_val  (db_val),
        .take     (acq_take),
        .count    (db_count),
        .positive (permit)
    );

    seq_exec #(.DEPTH(DEPTH)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (q_head),
        .empty     (q_empty),
        .occ       (q_occ),
        .push_ok   (cmd_push && !cmd_full),
        .hold      (exec_hold),
        .permit    (permit),
        .pop       (q_pop),
        .take      (acq_take),
        .bus_own   (bus_owned),
        .ovalid    (out_valid),
        .obyte     (out_byte),
        .core_idle (core_idle),
        .bad       (sm_bad)
    );

    assign idle = q_empty && core_idle;

endmodule

// File: rtl/dbseq_chk.sv
module dbseq_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             db_wr,
    input logic [CNT_W-1:0] db_val,
    input logic [CNT_W-1:0] db_count,
    input logic             acq_take,
    input logic             bus_owned,
    input logic             idle,
    input logic             q_empty,
    input logic             sm_bad
);

    // R2
    add_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && !acq_take) |=> (db_count == $past(db_count + db_val)));

    // R5
    add_and_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_wr && acq_take) |=> (db_count == $past(db_count + db_val - 1'b1)));

    // R4
    permit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_take |-> ($signed(db_count) > $signed({CNT_W{1'b0}})));

    // R3
    own_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_owned) |-> $past(acq_take));

    // R10
    idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (q_empty && !bus_owned));

    // R12
    no_bad_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sm_bad);

endmodule

bind dbell_seq dbseq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_wr     (db_wr),
    .db_val    (db_val),
    .db_count  (db_count),
    .acq_take  (acq_take),
    .bus_owned (bus_owned),
    .idle      (idle),
    .q_empty   (q_empty),
    .sm_bad    (sm_bad)
);

// File: tb/sim_dbell_seq.sv
`timescale 1ns/1ps
module sim_dbell_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_push = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       cmd_full;
    logic       db_wr = 1'b0;
    logic [7:0] db_val = '0;
    logic [7:0] db_count;
    logic       exec_hold = 1'b0;
    logic       bus_owned;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       idle;
    logic       sm_bad;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    dbell_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_byte(cmd_byte),
        .cmd_full(cmd_full), .db_wr(db_wr), .db_val(db_val), .db_count(db_count),
        .exec_hold(exec_hold), .bus_owned(bus_owned), .out_valid(out_valid),
        .out_byte(out_byte), .idle(idle), .sm_bad(sm_bad)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every payload strobe must match the oldest expected byte (R7)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7 actual=%0h expected=none", out_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (out_byte !== e) begin
                    n_fail++;
                    $display("FAIL R7 actual=%0h expected=%0h", out_byte, e);
                end
            end
        end
    end

    task automatic push(input logic [7:0] b);
        cmd_push = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic expect_byte(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    task automatic ring(input logic [7:0] v);
        db_wr = 1'b1; db_val = v;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 count", db_count, 8'h00);
        chk("R1 idle", idle, 1);
        chk("R1 bus", bus_owned, 0);
        chk("R1 valid", out_valid, 0);
        chk("R1 full", cmd_full, 0);
        chk("R1 bad", sm_bad, 0);
        idle_for(2);

        // R2 signed modular add
        ring(8'h7F);
        chk("R2 first add", db_count, 8'h7F);
        ring(8'h7F);
        chk("R2 wrap", db_count, 8'hFE);
        ring(8'h02);
        chk("R2 back to zero", db_count, 8'h00);

        // R7 plain payload order
        expect_byte(8'hA5); expect_byte(8'h5A); expect_byte(8'hC3);
        push(8'hA5); push(8'h5A); push(8'hC3);
        idle_for(6);
        chk("R7 drained", exp_q.size(), 0);

        // R4 negative count holds acquire
        ring(8'hFD);
        chk("R4 negative", db_count, 8'hFD);
        push(8'h01); push(8'h91); push(8'h02);
        idle_for(6);
        chk("R10 idle low while held", idle, 0);
        ring(8'h03);
        idle_for(4);
        chk("R4 zero still holds", db_count, 8'h00);
        chk("R4 nothing ran", bus_owned, 0);
        expect_byte(8'h91);
        ring(8'h01);
        idle_for(6);
        chk("R4 released", exp_q.size(), 0);
        chk("R3 consumed permit", db_count, 8'h00);
        chk("R10 idle after sequence", idle, 1);

        // R3 bus ownership
        push(8'h01); push(8'hA1);
        expect_byte(8'hA1);
        ring(8'h01);
        idle_for(4);
        chk("R3 owned", bus_owned, 1);
        chk("R10 not idle while owned", idle, 0);
        push(8'h02);
        idle_for(3);
        chk("R3 released", bus_owned, 0);

        // R5 add on same edge as take
        push(8'h01); push(8'h81); push(8'h02);
        idle_for(4);
        expect_byte(8'h81);
        db_wr = 1'b1; db_val = 8'h01;
        @(negedge clk);
        db_val = 8'h05;
        @(negedge clk);
        db_wr = 1'b0;
        chk("R5 count+val-1", db_count, 8'h05);
        idle_for(4);
        ring(8'hFB);
        chk("R5 cleanup", db_count, 8'h00);

        // R6 several sequences, one write
        push(8'h01); push(8'h71); push(8'h02);
        push(8'h01); push(8'h72); push(8'h02);
        push(8'h01); push(8'h73); push(8'h02);
        expect_byte(8'h71); expect_byte(8'h72);
        ring(8'h02);
        idle_for(10);
        chk("R6 two released", exp_q.size(), 0);
        chk("R6 count used", db_count, 8'h00);
        chk("R6 third held", idle, 0);
        expect_byte(8'h73);
        ring(8'h01);
        idle_for(6);
        chk("R6 third released", exp_q.size(), 0);
        chk("R10 idle end", idle, 1);

        // R9 hold: queued bytes still run, later ones wait
        push(8'h01); push(8'h33); push(8'h02);
        idle_for(3);
        exec_hold = 1'b1;
        idle_for(2);
        push(8'h44);
        expect_byte(8'h33);
        ring(8'h01);
        idle_for(10);
        chk("R9 snapshot ran", exp_q.size(), 0);
        chk("R9 later byte waits", idle, 0);
        expect_byte(8'h44);
        exec_hold = 1'b0;
        idle_for(4);
        chk("R9 resumed", exp_q.size(), 0);

        // R8 wait N=5 latency
        exec_hold = 1'b1;
        idle_for(2);
        push(8'h03); push(8'h05); push(8'h00); push(8'h55);
        expect_byte(8'h55);
        exec_hold = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!out_valid && k < 50);
        chk("R8 N=5 latency", k, 9);

        // R8 wait N=0 latency
        exec_hold = 1'b1;
        idle_for(2);
        push(8'h03); push(8'h00); push(8'h00); push(8'h66);
        expect_byte(8'h66);
        exec_hold = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!out_valid && k < 50);
        chk("R8 N=0 latency", k, 4);
        idle_for(2);

        // R11 overflow drop
        exec_hold = 1'b1;
        idle_for(2);
        for (int i = 0; i < 17; i++) push(8'h60 + 8'(i));
        chk("R11 full", cmd_full, 1);
        for (int i = 0; i < 16; i++) expect_byte(8'h60 + 8'(i));
        exec_hold = 1'b0;
        idle_for(30);
        chk("R11 dropped extra", exp_q.size(), 0);
        chk("R11 not full", cmd_full, 0);
        chk("R10 idle final", idle, 1);
        chk("R12 no bad state", sm_bad, 0);

        summary();
        $finish;
    end

endmodule